// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serializes bytes onto a single transmit line using an asynchronous frame format. It has two storage stages. Software writes a byte into a holding register, and a separate shift register drives the line. Because of this split, the next byte can be loaded while the current frame is still going out. A data-empty flag shows that the holding register may be written again. A transmit-end flag shows that the line has gone idle after the last frame. Each flag drives a level interrupt request through its own enable input.

An external baud tick paces the block, and each bit lasts sixteen ticks. Static configuration inputs select:
- seven or eight data bits;
- an optional extra bit, which is either even or odd parity or a multiprocessor flag;
- one or two stop bits.

At the first cycle of the stop bit, the block checks whether software has supplied another byte. If it has, the next frame follows the stop bit with no idle gap. If it has not, the transmit-end flag is raised and the line stays at mark (1).

States:
- `ST_IDLE`: line at 1.
- `ST_START`: line at 0.
- `ST_DATA`: shift register bit 0 on the line.
- `ST_EXTRA`: parity or multiprocessor bit.
- `ST_STOP`: line at 1.

Transitions:
- IDLE→START when the holding register is full. The byte is transferred at this edge.
- START→DATA after one bit time.
- DATA→EXTRA after the last data bit, when an extra bit is configured.
- DATA→STOP after the last data bit, when no extra bit is configured. The pending check happens on this edge.
- EXTRA→STOP after one bit time. The pending check happens on this edge.
- STOP→START at the end of the stop period, when a byte was transferred at the check.
- STOP→IDLE at the end of the stop period otherwise.
- Any state→IDLE while the transmitter is disabled.

Top module: `sertx_dbuf`

## Requirements
- R1: While `tx_en` is 0, `tx_line` is 1, `empty_flag` is 1, `end_flag` is 1, and writes are ignored, so no frame starts after the block is enabled.
- R2: A write (`wr_stb`=1) while the block is enabled stores `wr_data` and clears both `empty_flag` and `end_flag` on the next cycle.
- R3: In idle, when a byte is waiting, the block transfers it to the shift register, sets `empty_flag` to 1 and starts the frame. `irq_empty` equals `empty_flag` AND `tie`.
- R4: The line order is:
  - a start bit of 0;
  - the data bits, least significant first, 8 bits or 7 bits when `cfg_len7`=1;
  - the extra bit, if any;
  - a stop bit of 1.
- R5: Every bit after the start bit lasts exactly 16 baud ticks. The start bit lasts 16 ticks, counted from the first tick after the transfer.
- R6: With `cfg_par_en`=1, the extra bit is the XOR of the sent data bits, inverted when `cfg_par_odd`=1. Otherwise, with `cfg_mp_en`=1, the extra bit is `mp_bit` sampled at the transfer. When both are 0, no extra bit is sent. Parity wins if both are set.
- R7: If `empty_flag` is 0 when the stop bit begins, the byte is transferred at that moment, `end_flag` stays 0, and the next start bit follows the stop period directly.
- R8: If `empty_flag` is 1 when the stop bit begins, `end_flag` becomes 1, and after the stop period the line idles at 1.
- R9: With `cfg_stop2`=1, the stop period is two bit times at 1.
- R10: `irq_end` equals `end_flag` AND `teie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Byte to write |
| cfg_len7 | input | 1 | 1 = seven data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity |
| cfg_mp_en | input | 1 | Multiprocessor bit enable |
| mp_bit | input | 1 | Multiprocessor bit value |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| tie | input | 1 | Data-empty interrupt enable |
| teie | input | 1 | Transmit-end interrupt enable |
| tx_line | output | 1 | Serial output |
| empty_flag | output | 1 | Holding register empty |
| end_flag | output | 1 | Transmission ended |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The hardest case to reach is the stop-bit check finding a byte already waiting. To get there, a second byte must be written after the first has moved into the shift register but before its stop bit begins. The bench waits for `empty_flag` to return to 1 during the first frame's start bit and then writes the second byte. It then follows both frames bit by bit. It checks that `end_flag` stays 0 in the middle of the stop bit and that the line reads 0 one bit time after the stop centre.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_EXTRA = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          wr_stb_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          take_i,
    input  logic          mark_end_i,
    output logic [DW-1:0] hold_o,
    output logic          empty_o,
    output logic          end_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o  <= '0;
            empty_o <= 1'b1;
            end_o   <= 1'b1;
        end else if (!en_i) begin
            empty_o <= 1'b1;
            end_o   <= 1'b1;
        end else begin
            if (wr_stb_i) begin
                hold_o  <= wr_data_i;
                empty_o <= 1'b0;
                end_o   <= 1'b0;
            end else begin
                if (take_i)     empty_o <= 1'b1;
                if (mark_end_i) end_o   <= 1'b1;
            end
        end
    end

    // R2: a write clears both flags
    a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_stb_i) |=> (!empty_o && !end_o));
    // R3: a transfer frees the holding register
    a_r3_take_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && take_i && !wr_stb_i) |=> empty_o);
    // R1: flags forced while disabled
    a_r1_off_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (empty_o && end_o));
endmodule

// File: rtl/sertx_bittmr.sv
module sertx_bittmr #(
    parameter int TPB = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic bit_done_o
);
    localparam int CW = $clog2(TPB);
    localparam logic [CW-1:0] LAST = CW'(TPB - 1);

    logic [CW-1:0] cnt_q;

    assign bit_done_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr_i)        cnt_q <= '0;
        else if (bit_done_o)   cnt_q <= '0;
        else if (tick_i)       cnt_q <= cnt_q + 1'b1;
    end

    // R5: the count only moves on baud ticks
    a_r5_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          bit_done_i,
    input  logic          empty_i,
    input  logic [DW-1:0] hold_i,
    input  logic          len_short_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic          mp_en_i,
    input  logic          mp_bit_i,
    input  logic          stop2_i,
    output logic          take_o,
    output logic          mark_end_o,
    output logic          tmr_clr_o,
    output logic          tx_o
);
    localparam int BW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_L = BW'(DW - 1);
    localparam logic [BW-1:0] LAST_S = BW'(DW - 2);

    tx_state_t     state_q, state_d;
    logic [DW-1:0] shreg_q;
    logic [BW-1:0] bit_idx_q;
    logic          xbit_q;
    logic          stop_idx_q;
    logic          pend_q;
    logic          chk;
    logic          extra_on;
    logic          last_data;
    logic          stop_end;
    logic [DW-1:0] mask;

    assign extra_on  = par_en_i || mp_en_i;
    assign last_data = bit_idx_q == (len_short_i ? LAST_S : LAST_L);
    assign stop_end  = bit_done_i && (stop_idx_q == stop2_i);
    assign mask      = len_short_i ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};

    // next-state and handshake pulses
    always_comb begin
        state_d    = state_q;
        chk        = 1'b0;
        take_o     = 1'b0;
        mark_end_o = 1'b0;
        tmr_clr_o  = (state_q == ST_IDLE);
        unique case (state_q)
            ST_IDLE: begin
                if (!empty_i) begin
                    take_o  = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_done_i) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_done_i && last_data) begin
                    if (extra_on) begin
                        state_d = ST_EXTRA;
                    end else begin
                        state_d = ST_STOP;
                        chk     = 1'b1;
                    end
                end
            end
            ST_EXTRA: begin
                if (bit_done_i) begin
                    state_d = ST_STOP;
                    chk     = 1'b1;
                end
            end
            ST_STOP: begin
                if (stop_end) state_d = pend_q ? ST_START : ST_IDLE;
            end
        endcase
        if (chk) begin
            if (!empty_i) take_o     = 1'b1;
            else          mark_end_o = 1'b1;
        end
        if (!en_i) begin
            state_d    = ST_IDLE;
            take_o     = 1'b0;
            mark_end_o = 1'b0;
            tmr_clr_o  = 1'b1;
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            shreg_q    <= '0;
            bit_idx_q  <= '0;
            xbit_q     <= 1'b0;
            stop_idx_q <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_o) begin
                shreg_q <= hold_i;
                xbit_q  <= par_en_i ? ((^(hold_i & mask)) ^ par_odd_i) : mp_bit_i;
            end else if (state_q == ST_DATA && bit_done_i) begin
                shreg_q <= shreg_q >> 1;
            end
            if (state_q == ST_START) begin
                bit_idx_q <= '0;
            end else if (state_q == ST_DATA && bit_done_i) begin
                bit_idx_q <= bit_idx_q + 1'b1;
            end
            if (chk) begin
                pend_q     <= !empty_i;
                stop_idx_q <= 1'b0;
            end else if (state_q == ST_STOP && bit_done_i) begin
                stop_idx_q <= 1'b1;
            end
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            ST_IDLE:  tx_o = 1'b1;
            ST_START: tx_o = 1'b0;
            ST_DATA:  tx_o = shreg_q[0];
            ST_EXTRA: tx_o = xbit_q;
            ST_STOP:  tx_o = 1'b1;
            default:  tx_o = 1'b1;
        endcase
    end

    // R7: pending byte at the check leads straight into a new start bit
    a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_STOP && stop_end && pend_q) |=> (state_q == ST_START));
    // R8: nothing pending -> idle after the stop period
    a_r8_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_STOP && stop_end && !pend_q) |=> (state_q == ST_IDLE && tx_o));
    // R1: disabling forces idle mark
    a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_IDLE && tx_o));
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          baud_tick,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          cfg_len7,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_mp_en,
    input  logic          mp_bit,
    input  logic          cfg_stop2,
    input  logic          tie,
    input  logic          teie,
    output logic          tx_line,
    output logic          empty_flag,
    output logic          end_flag,
    output logic          irq_empty,
    output logic          irq_end
);
    logic [DW-1:0] hold;
    logic          take, mark_end, tmr_clr, bit_done;

    sertx_hold #(.DW(DW)) hold_i (
        .clk(clk), .rst_n(rst_n), .en_i(tx_en),
        .wr_stb_i(wr_stb), .wr_data_i(wr_data),
        .take_i(take), .mark_end_i(mark_end),
        .hold_o(hold), .empty_o(empty_flag), .end_o(end_flag)
    );

    sertx_bittmr #(.TPB(TPB)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr),
        .tick_i(baud_tick), .bit_done_o(bit_done)
    );

    sertx_fsm #(.DW(DW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .en_i(tx_en),
        .bit_done_i(bit_done), .empty_i(empty_flag), .hold_i(hold),
        .len_short_i(cfg_len7), .par_en_i(cfg_par_en), .par_odd_i(cfg_par_odd),
        .mp_en_i(cfg_mp_en), .mp_bit_i(mp_bit), .stop2_i(cfg_stop2),
        .take_o(take), .mark_end_o(mark_end), .tmr_clr_o(tmr_clr), .tx_o(tx_line)
    );

    assign irq_empty = empty_flag && tie;
    assign irq_end   = end_flag && teie;
endmodule

// File: tb/sertx_dbuf_tb_top.sv
module sertx_dbuf_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_len7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_mp_en = 0;
    logic       mp_bit = 0, cfg_stop2 = 0, tie = 1, teie = 1;
    logic       tx_line, empty_flag, end_flag, irq_empty, irq_end;
    logic       tdiv = 1'b0;
    int         n_chk = 0, n_bad = 0;
    bit         finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv      <= ~tdiv;
        baud_tick <= tdiv;
    end

    sertx_dbuf dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tx_line == 1'b0) break;
        end
    endtask

    // follow one frame; ends at the centre of the bit after the stop period
    task automatic run_frame(input logic [7:0] d, input bit skip_wait, input bit follow);
        int nb = cfg_len7 ? 7 : 8;
        logic [7:0] md = cfg_len7 ? (d & 8'h7f) : d;
        if (!skip_wait) begin
            wait_start();
            repeat (16) @(negedge clk);
        end
        check("R4 start bit", tx_line, 0);
        for (int i = 0; i < nb; i++) begin
            repeat (32) @(negedge clk);
            check("R4 data bit", tx_line, md[i]);
        end
        if (cfg_par_en || cfg_mp_en) begin
            repeat (32) @(negedge clk);
            check("R6 extra bit", tx_line, cfg_par_en ? ((^md) ^ cfg_par_odd) : mp_bit);
        end
        repeat (32) @(negedge clk);
        check("R4 stop bit", tx_line, 1);
        check(follow ? "R7 end flag low" : "R8 end flag set", end_flag, !follow);
        if (cfg_stop2) begin
            repeat (32) @(negedge clk);
            check("R9 second stop bit", tx_line, 1);
        end
        repeat (32) @(negedge clk);
        check(follow ? "R7 next start" : "R8 idle mark", tx_line, follow ? 0 : 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset tx", tx_line, 1);
        check("R1 reset empty", empty_flag, 1);
        check("R1 reset end", end_flag, 1);
        check("R10 irq_end", irq_end, 1);
    endtask

    task automatic t_disabled_write();
        do_write(8'h55);
        repeat (50) @(negedge clk);
        check("R1 off empty", empty_flag, 1);
        tx_en = 1'b1;
        repeat (400) @(negedge clk);
        check("R1 no frame after enable", tx_line, 1);
        check("R1 still empty", empty_flag, 1);
    endtask

    task automatic t_single();
        do_write(8'hA5);
        check("R2 empty cleared", empty_flag, 0);
        check("R2 end cleared", end_flag, 0);
        check("R10 irq_end low", irq_end, 0);
        check("R3 irq_empty low", irq_empty, 0);
        repeat (3) @(negedge clk);
        check("R3 empty after transfer", empty_flag, 1);
        check("R3 irq_empty", irq_empty, 1);
        run_frame(8'hA5, 0, 0);
        check("R10 irq_end high", irq_end, 1);
        teie = 1'b0; #1;
        check("R10 irq_end masked", irq_end, 0);
        teie = 1'b1;
    endtask

    task automatic t_timing();
        int lo = 0, hi = 0;
        do_write(8'h01);
        wait_start();
        while (tx_line == 1'b0 && lo < 100) begin @(negedge clk); lo++; end
        while (tx_line == 1'b1 && hi < 100) begin @(negedge clk); hi++; end
        check("R5 start length", (lo == 31 || lo == 32), 1);
        check("R5 bit length", hi, 32);
        repeat (400) @(negedge clk);
    endtask

    task automatic t_len7_odd();
        cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 1;
        do_write(8'hB3);
        run_frame(8'hB3, 0, 0);
        cfg_par_odd = 0; cfg_len7 = 0;
        do_write(8'h6C);
        run_frame(8'h6C, 0, 0);
        cfg_par_en = 0;
    endtask

    task automatic t_mp();
        cfg_mp_en = 1; mp_bit = 1;
        do_write(8'h3E);
        run_frame(8'h3E, 0, 0);
        cfg_par_en = 1; mp_bit = 0;   // R6 parity wins
        do_write(8'h07);
        run_frame(8'h07, 0, 0);
        cfg_par_en = 0; cfg_mp_en = 0;
    endtask

    task automatic t_b2b();
        do_write(8'hC9);
        for (int i = 0; i < 20 && empty_flag == 1'b0; i++) @(negedge clk);
        do_write(8'h5A);
        check("R3 irq_empty with pending", irq_empty, 0);
        run_frame(8'hC9, 0, 1);
        run_frame(8'h5A, 1, 0);
    endtask

    task automatic t_stop2();
        cfg_stop2 = 1;
        do_write(8'h96);
        run_frame(8'h96, 0, 0);
        do_write(8'hE1);
        for (int i = 0; i < 20 && empty_flag == 1'b0; i++) @(negedge clk);
        do_write(8'h1F);
        run_frame(8'hE1, 0, 1);
        run_frame(8'h1F, 1, 0);
        cfg_stop2 = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_write();
        t_single();
        t_timing();
        t_len7_odd();
        t_mp();
        t_b2b();
        t_stop2();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule